// File: doc/BRIEF.md
# Gap-Synchronised Disk Read Deserialiser

This block turns the serial bit stream coming off a spinning disk into bytes for a host. Each record on the disk is preceded by a run of zero bits. After the host arms a hunt, the block throws away zeros until the first one bit appears. That one bit is the sync marker. It starts byte framing and also seeds the record's check value.

Data bits then fill a shift register least-significant bit first. Every eighth bit copies the assembled byte into a latch that the host can read. At the same time the block sets a byte-ready flag and, when enabled, raises an interrupt. A reflected CRC-16 (polynomial 0x8408) runs over the marker and every data bit. If the record's two check bytes are read as well, the remainder ends at zero.

The host controls the block through an 8-bit control word. It reads the latch and a status byte, and either read acknowledges the pending byte. Drive motion and the write path sit outside this block. The block only accepts a bit when the drive reports that it is running and no transfer reset is active.

Top module: `gap_sync_reader`

## Requirements
- R1: After reset the data latch, control word, CRC register, byte-ready flag and interrupt are all zero.
- R2: A control write that takes control bit 6 from 0 to 1 arms the gap hunt. While hunting with control bit 4 clear, a 0 bit changes neither the CRC nor the byte counter and completes no byte.
- R3: While hunting with control bit 4 clear, the first 1 bit ends the hunt and restarts byte framing. It leaves the CRC equal to 0x8408, which is the result of stepping a zero register with a 1.
- R4: Each accepted data bit steps the CRC as follows. The feedback is crc[0] XOR bit, the register shifts right by one, and it is XORed with 0x8408 when the feedback is 1. A record followed by its CRC low byte and then its high byte leaves the CRC at 0.
- R5: Data bits fill byte positions 0 up to 7 in arrival order. The eighth bit copies the byte to `rd_data` and sets the byte-ready flag.
- R6: A byte completion raises `irq` only when control bit 7 is 1.
- R7: While control bit 4 is 1, an armed hunt is suspended and bits are taken as data. A byte completion clears control bit 4.
- R8: A data-latch read (`data_rd`) clears the byte-ready flag and `irq` in the next cycle.
- R9: `status` shows the byte-ready flag in bit 1, CRC not zero in bit 4, `end_of_disk` in bit 6 and `writable` in bit 7, with the other bits 0. A status read (`stat_rd`) clears the flag and `irq`.
- R10: Any control write clears `irq` and leaves the byte-ready flag unchanged.
- R11: A bit is taken only on a `bit_tick` cycle with `running` high, `xfer_reset` low and control bit 2 (read mode) high. Otherwise it has no effect.
- R12: A control write that keeps bit 6 at 1 does not re-arm the hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a valid disk bit |
| bit_in | input | 1 | Disk bit value |
| running | input | 1 | Drive is spinning over the media |
| xfer_reset | input | 1 | Transfer reset active; bits are ignored |
| end_of_disk | input | 1 | Head at end of media, reported in status bit 6 |
| writable | input | 1 | Media writable, reported in status bit 7 |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word value |
| data_rd | input | 1 | Host read of the data latch |
| stat_rd | input | 1 | Host read of the status byte |
| ctrl_q | output | 8 | Current control word |
| rd_data | output | 8 | Latched received byte |
| status | output | 8 | Status byte |
| irq | output | 1 | Byte-completion interrupt |
| crc_value | output | 16 | CRC register |

## Verification
A framing counter that is off by one bit shows up at `rd_data` on the very next completed byte, as a rotated or shifted value. A CRC feedback fault shows up as a changed `crc_value` one cycle after the marker, and as a nonzero remainder after the check bytes. A hunt flag that is stuck or armed at the wrong time makes the flag rise during the gap, or makes the marker land inside a data byte. Either fault is visible within eight ticks. Faults in flag and interrupt clearing show in the cycle right after the host access.

// File: rtl/gap_sync_reader.sv
module gap_sync_reader #(
  parameter int BYTE_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              bit_in,
  input  logic              running,
  input  logic              xfer_reset,
  input  logic              end_of_disk,
  input  logic              writable,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [7:0]        ctrl_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic [7:0]        status,
  output logic              irq,
  output logic [CRC_W-1:0]  crc_value
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  localparam int READ_B = 2;
  localparam int CRCM_B = 4;
  localparam int ARM_B  = 6;
  localparam int IEN_B  = 7;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    crc_step = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY : '0);
  endfunction

  logic              hunt_q, flag_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] shift_q, shift_nx;

  wire take     = bit_tick & running & ~xfer_reset & ctrl_q[READ_B];
  wire hunt_now = hunt_q & ~ctrl_q[CRCM_B];
  wire gap_bit  = take & hunt_now;
  wire data_bit = take & ~hunt_now;
  wire done     = data_bit & (cnt_q == LAST);
  wire ack      = data_rd | stat_rd;
  wire arm      = ctrl_we & ~ctrl_q[ARM_B] & ctrl_wdata[ARM_B];

  always_comb begin
    shift_nx = shift_q;
    shift_nx[cnt_q] = bit_in;
  end

  assign status = {writable, end_of_disk, 1'b0, |crc_value, 2'b00, flag_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hunt_q    <= 1'b0;
      cnt_q     <= '0;
      shift_q   <= '0;
      rd_data   <= '0;
      flag_q    <= 1'b0;
      irq       <= 1'b0;
      crc_value <= '0;
    end else begin
      if (gap_bit && bit_in) begin
        hunt_q    <= 1'b0;
        cnt_q     <= '0;
        crc_value <= crc_step('0, 1'b1);
      end
      if (data_bit) begin
        crc_value <= crc_step(crc_value, bit_in);
        shift_q   <= shift_nx;
        cnt_q     <= done ? '0 : cnt_q + 1'b1;
        if (done) rd_data <= shift_nx;
      end
      if (arm) hunt_q <= 1'b1;

      if (done) flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;

      if (done && ctrl_q[IEN_B]) irq <= 1'b1;
      else if (ack || ctrl_we) irq <= 1'b0;

      if (ctrl_we) ctrl_q <= ctrl_wdata;
      else if (done) ctrl_q[CRCM_B] <= 1'b0;
    end
  end

  // R11
  ignored_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_value) && $stable(rd_data));

  // R3
  marker_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_bit && bit_in |=> crc_value == CRC_POLY);

  // R8
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !done |=> !status[1] && !irq);

  // R10
  ctrl_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !done |=> !irq);

  // R6
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_q[IEN_B]));

  // R2
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_bit && !bit_in |=> $stable(crc_value) && $stable(cnt_q));
endmodule

// File: tb/gap_sync_reader_tb_top.sv
module gap_sync_reader_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 4;
  // {stimulus byte, expected latch value}
  localparam logic [15:0] VEC [NVEC] = '{16'hA5A5, 16'h0101, 16'h8080, 16'h3C3C};

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, bit_in = 0, running = 1, xfer_reset = 0;
  logic end_of_disk = 0, writable = 0;
  logic ctrl_we = 0, data_rd = 0, stat_rd = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [7:0] ctrl_q, rd_data, status;
  logic irq;
  logic [15:0] crc_value;
  int checks = 0, failures = 0;
  logic [15:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  gap_sync_reader dut_i (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_in(bit_in),
    .running(running), .xfer_reset(xfer_reset), .end_of_disk(end_of_disk), .writable(writable),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .data_rd(data_rd), .stat_rd(stat_rd),
    .ctrl_q(ctrl_q), .rd_data(rd_data), .status(status), .irq(irq), .crc_value(crc_value));

  function automatic logic [15:0] mstep(input logic [15:0] c, input logic b);
    mstep = (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_tick = 1; bit_in = b;
    @(negedge clk); bit_tick = 0; bit_in = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit track);
    for (int i = 0; i < 8; i++) begin
      if (track) model = mstep(model, v[i]);
      send_bit(v[i]);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic rd_data_pulse();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk); stat_rd = 1; v = status;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] st;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(rd_data == 0 && ctrl_q == 0 && crc_value == 0 && !irq && status == 0, "R1",
          {rd_data, ctrl_q, crc_value}, 0);

    wr_ctrl(8'h84);
    wr_ctrl(8'hC4);
    // R2 gap of zeros discarded
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    check(crc_value == 0 && !status[1], "R2", crc_value, 0);
    // R3 marker
    send_bit(1'b1);
    check(crc_value == 16'h8408, "R3", crc_value, 16'h8408);
    model = 16'h8408;

    for (int k = 0; k < NVEC; k++) begin
      send_byte(VEC[k][15:8], 1);
      // R5
      check(rd_data == VEC[k][7:0] && status[1], "R5", rd_data, VEC[k][7:0]);
      // R6
      check(irq == 1'b1, "R6", irq, 1);
      // R4
      check(crc_value == model, "R4", crc_value, model);
      if (k == NVEC - 1) begin
        wr_ctrl(8'hC4);
        // R10
        check(!irq && status[1], "R10", {irq, status[1]}, 2'b01);
      end
      rd_data_pulse();
      // R8
      check(!irq && !status[1], "R8", {irq, status[1]}, 0);
    end
    held = model;
    send_byte(held[7:0], 1);
    send_byte(held[15:8], 1);
    // R4 record closes to zero
    check(crc_value == 16'h0000 && !status[4], "R4", crc_value, 0);

    end_of_disk = 1; writable = 1;
    rd_stat(st);
    // R9
    check(st == 8'hC2, "R9", st, 8'hC2);
    @(negedge clk);
    check(!status[1] && !irq, "R9", {status[1], irq}, 0);

    // R12 bit 6 held high: no re-arm, bits go straight to data
    wr_ctrl(8'hC4);
    send_byte(8'h00, 0);
    check(status[1] && rd_data == 8'h00, "R12", status, 8'hC2);
    rd_data_pulse();

    // R11 bits ignored when not allowed
    held = crc_value;
    running = 0; send_bit(1'b1); running = 1;
    xfer_reset = 1; send_bit(1'b1); xfer_reset = 0;
    wr_ctrl(8'hC0); send_bit(1'b1);
    check(crc_value == held && !status[1], "R11", crc_value, held);

    // R7 CRC mode suspends an armed hunt, cleared at byte end
    wr_ctrl(8'h04);
    wr_ctrl(8'h54);
    send_byte(8'h5A, 0);
    check(rd_data == 8'h5A && status[1], "R7", rd_data, 8'h5A);
    check(ctrl_q == 8'h44, "R7", ctrl_q, 8'h44);
    // R6 interrupt disabled
    check(!irq, "R6", irq, 0);
    rd_data_pulse();
    // hunt now resumes: zeros discarded, marker seeds CRC
    held = crc_value;
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    check(crc_value == held, "R2", crc_value, held);
    send_bit(1'b1);
    check(crc_value == 16'h8408, "R3", crc_value, 16'h8408);
    check(status[4], "R9", status, 8'hD0);

    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(ctrl_q == 0 && crc_value == 0 && rd_data == 0 && !irq, "R1", {ctrl_q, crc_value}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule